// File: doc/BRIEF.md
# External Interrupt Request Latch

This block gathers every external interrupt input of a small 8-bit processor into one latched request. Two kinds of input feed it. The first is a dedicated active-low interrupt pin. The second is a set of general-purpose port pins, and each of these counts as an interrupt input only while its pullup is enabled and it is configured as an input. All enabled inputs are OR-ed together. A falling edge on any of them sets the request latch.

A single trigger-mode input picks how the latch responds. In edge-only mode, a falling edge is the only thing that sets the latch. In edge-plus-level mode, a low level on any enabled input also keeps setting the latch.

The processor clears the latch when it fetches the external interrupt vector. This lets a new edge be captured while the service routine runs. The processor's interrupt mask bit gates only the request sent to the processor; the latch keeps capturing while the mask is set. Power-on reset, watchdog reset and external reset all clear the latch.

All pin inputs pass through a synchronizer before edge detection. The masked request is a registered level that the processor samples at its own instruction boundaries.

Top module: `ext_irq_latch`

## Requirements
- R1: After power-on reset, `irq_latched_o` and `irq_to_cpu_o` are 0. All synchronizer and previous-level state comes out of reset as high (idle).
- R2: A falling edge on the dedicated pin sets `irq_latched_o` in either trigger mode. The pin is sampled on a clock edge; with the default two synchronizer stages, the output first reads 1 after the third rising clock edge from that sample.
- R3: With `trig_level_i` = 0 (edge only), an input held low does not set the latch again after it has been cleared. The input must go high and then fall again to produce a new request.
- R4: With `trig_level_i` = 1 (edge plus level), the latch is set on every cycle in which any enabled input is low after synchronization. A vector-fetch clear therefore has no visible effect while such an input stays low.
- R5: Port pin `i` is an interrupt input only when `port_pullup_en_i[i]` = 1 and `port_dir_out_i[i]` = 0. A port pin with the pullup disabled, or with the pin set as an output, never affects the latch.
- R6: The dedicated pin and all enabled port pins are OR-ed into one request. A falling edge on any enabled port pin sets the same latch as the dedicated pin.
- R7: A one-cycle `vec_fetch_ack_i` pulse clears the latch on that clock edge. If a set condition is present in the same cycle, the set wins and the latch stays 1.
- R8: `irq_to_cpu_o` equals `irq_latched_o` while `cpu_mask_i` = 0, and reads 0 while `cpu_mask_i` = 1. The latch still captures requests while the mask is set.
- R9: `wdog_rst_i` or `ext_rst_i` held high during a clock edge clears the latch on that edge. These resets take priority over any set condition.
- R10: A port pin that becomes enabled while it is already low does not produce a falling edge. Only a later high-to-low transition can set the latch in edge-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| wdog_rst_i | input | 1 | Watchdog reset, synchronous, active high |
| ext_rst_i | input | 1 | External reset, synchronous, active high |
| irq_pin_n_i | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_pin_i | input | NUM_PORT_PINS | Port pin levels, asynchronous |
| port_pullup_en_i | input | NUM_PORT_PINS | Per-pin pullup enable (1 = enabled) |
| port_dir_out_i | input | NUM_PORT_PINS | Per-pin direction (1 = output, 0 = input) |
| trig_level_i | input | 1 | Trigger mode: 0 = edge only, 1 = edge plus low level |
| cpu_mask_i | input | 1 | Processor interrupt mask (1 = masked) |
| vec_fetch_ack_i | input | 1 | Pulse while the external interrupt vector is fetched |
| irq_latched_o | output | 1 | Raw latched external request |
| irq_to_cpu_o | output | 1 | Request to the processor after masking |

## Verification
The bench clears the latch while a pin is still held low, in both trigger modes. A design that mixes up the two modes would either lose a level request or set the latch again from a single edge. The bench also lines up a synchronized falling edge with the vector-fetch pulse in the same cycle; a design with the wrong priority would drop that request. It enables a port pin that is already low, and a design without previous-level tracking would report a request that never happened. It also holds a watchdog or external reset against a low level input, which exposes any design that lets the set condition beat the reset.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Trigger mode encoding seen on trig_level_i
    typedef enum logic {
        TRIG_EDGE_ONLY  = 1'b0,
        TRIG_EDGE_LEVEL = 1'b1
    } trig_mode_e;

    // Registered state of the request core
    typedef struct packed {
        logic latch;
    } req_state_t;

    localparam logic LVL_IDLE = 1'b1;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    import ext_irq_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.stg[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            state_d.stg[k] = state_q.stg[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= '{stg: {STAGES*WIDTH{LVL_IDLE}}};
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.stg[STAGES-1];

endmodule

// File: rtl/eirq_src_detect.sv
module eirq_src_detect #(
    parameter int WIDTH = 9
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] qual_i,
    output logic             fall_any_o,
    output logic             low_any_o
);
    import ext_irq_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } det_state_t;

    det_state_t       state_d, state_q;
    logic [WIDTH-1:0] fall_vec;
    logic [WIDTH-1:0] low_vec;

    // Previous level always tracks the pin, qualified or not, so that a
    // pin becoming qualified while low has prev = low and shows no edge.
    always_comb begin
        state_d      = state_q;
        state_d.prev = lvl_i;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_src
            assign fall_vec[g] = qual_i[g] & state_q.prev[g] & ~lvl_i[g];
            assign low_vec[g]  = qual_i[g] & ~lvl_i[g];
        end
    endgenerate

    assign fall_any_o = |fall_vec;
    assign low_any_o  = |low_vec;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= '{prev: {WIDTH{LVL_IDLE}}};
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/eirq_req_core.sv
module eirq_req_core (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic sync_clr_i,
    input  logic fall_any_i,
    input  logic low_any_i,
    input  logic trig_level_i,
    input  logic vec_fetch_ack_i,
    output logic latch_o
);
    import ext_irq_pkg::*;

    req_state_t state_d, state_q;
    logic       set_req;

    always_comb begin
        set_req = fall_any_i | ((trig_mode_e'(trig_level_i) == TRIG_EDGE_LEVEL) & low_any_i);
        state_d = state_q;
        if (sync_clr_i) begin
            state_d.latch = 1'b0;
        end else if (set_req) begin
            state_d.latch = 1'b1;
        end else if (vec_fetch_ack_i) begin
            state_d.latch = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= '{latch: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign latch_o = state_q.latch;

    // R2
    set_takes_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (fall_any_i && !sync_clr_i) |=> latch_o);

    // R7
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (vec_fetch_ack_i && !fall_any_i && !(trig_level_i && low_any_i) && !sync_clr_i) |=> !latch_o);

    // R9
    sync_rst_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        sync_clr_i |=> !latch_o);

    // R3
    rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(latch_o) |-> $past(fall_any_i || (trig_level_i && low_any_i)));

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
    parameter int NUM_PORT_PINS = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                     clk_i,
    input  logic                     por_n_i,
    input  logic                     wdog_rst_i,
    input  logic                     ext_rst_i,
    input  logic                     irq_pin_n_i,
    input  logic [NUM_PORT_PINS-1:0] port_pin_i,
    input  logic [NUM_PORT_PINS-1:0] port_pullup_en_i,
    input  logic [NUM_PORT_PINS-1:0] port_dir_out_i,
    input  logic                     trig_level_i,
    input  logic                     cpu_mask_i,
    input  logic                     vec_fetch_ack_i,
    output logic                     irq_latched_o,
    output logic                     irq_to_cpu_o
);
    localparam int SRC_W = NUM_PORT_PINS + 1;

    logic [SRC_W-1:0] src_raw;
    logic [SRC_W-1:0] src_sync;
    logic [SRC_W-1:0] src_qual;
    logic             fall_any;
    logic             low_any;
    logic             latch;

    // Top bit is the dedicated pin, always qualified
    assign src_raw  = {irq_pin_n_i, port_pin_i};
    assign src_qual = {1'b1, port_pullup_en_i & ~port_dir_out_i};

    eirq_sync #(
        .WIDTH  (SRC_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .async_i (src_raw),
        .sync_o  (src_sync)
    );

    eirq_src_detect #(
        .WIDTH (SRC_W)
    ) det_i (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .lvl_i      (src_sync),
        .qual_i     (src_qual),
        .fall_any_o (fall_any),
        .low_any_o  (low_any)
    );

    eirq_req_core core_i (
        .clk_i           (clk_i),
        .por_n_i         (por_n_i),
        .sync_clr_i      (wdog_rst_i | ext_rst_i),
        .fall_any_i      (fall_any),
        .low_any_i       (low_any),
        .trig_level_i    (trig_level_i),
        .vec_fetch_ack_i (vec_fetch_ack_i),
        .latch_o         (latch)
    );

    assign irq_latched_o = latch;
    assign irq_to_cpu_o  = latch & ~cpu_mask_i;

    // R8
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (cpu_mask_i && irq_latched_o && !wdog_rst_i && !ext_rst_i && !vec_fetch_ack_i) |=> irq_latched_o);

endmodule

// File: tb/ext_irq_latch_tb_top.sv
module ext_irq_latch_tb_top;
    localparam int N = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic wd = 1'b0, er = 1'b0;
    logic irq_n = 1'b1;
    logic [N-1:0] pin = '1, pu = '0, dout = '0;
    logic mode = 1'b0, mask = 1'b0, ack = 1'b0;
    logic lat, cpu;

    int checks = 0, fails = 0, cyc = 0;
    string phase = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_latch #(.NUM_PORT_PINS(N), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .por_n_i(por_n), .wdog_rst_i(wd), .ext_rst_i(er),
        .irq_pin_n_i(irq_n), .port_pin_i(pin), .port_pullup_en_i(pu),
        .port_dir_out_i(dout), .trig_level_i(mode), .cpu_mask_i(mask),
        .vec_fetch_ack_i(ack), .irq_latched_o(lat), .irq_to_cpu_o(cpu));

    // Behavioural reference: two sample delays, per-input last level, latch
    bit m_s1[N+1], m_s2[N+1], m_prev[N+1];
    bit m_latch;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            foreach (m_s1[j]) begin m_s1[j] = 1; m_s2[j] = 1; m_prev[j] = 1; end
            m_latch = 0;
        end else begin
            bit fall, low, en;
            fall = 0; low = 0;
            for (int j = 0; j <= N; j++) begin
                en = (j == N) ? 1'b1 : (pu[j] && !dout[j]);
                if (en && m_prev[j] && !m_s2[j]) fall = 1;
                if (en && !m_s2[j]) low = 1;
            end
            if (wd || er) m_latch = 0;
            else if (fall || (mode && low)) m_latch = 1;
            else if (ack) m_latch = 0;
            for (int j = 0; j <= N; j++) begin
                m_prev[j] = m_s2[j];
                m_s2[j] = m_s1[j];
                m_s1[j] = (j == N) ? irq_n : pin[j];
            end
        end
    end

    task automatic check(string req, bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check(phase, lat, m_latch, "model latched");
        check(phase, cpu, m_latch && !mask, "model to_cpu");
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        steps(3);
        por_n = 1'b1;
        step();
        // R1
        check("R1", lat, 1'b0, "latched after reset");
        check("R1", cpu, 1'b0, "to_cpu after reset");
        steps(2);

        // R2: edge on dedicated pin, timing
        phase = "R2";
        irq_n = 0;
        steps(2);
        check("R2", lat, 1'b0, "latched after two edges");
        step();
        check("R2", lat, 1'b1, "latched after three edges");
        check("R2", cpu, 1'b1, "to_cpu unmasked");

        // R3: edge mode, held low, clear stays clear
        phase = "R3";
        ack = 1; step(); ack = 0;
        check("R3", lat, 1'b0, "cleared by ack");
        steps(5);
        check("R3", lat, 1'b0, "held low no retrigger");
        irq_n = 1; steps(4);
        irq_n = 0; steps(3);
        check("R3", lat, 1'b1, "new fall retriggers");
        ack = 1; step(); ack = 0;

        // R4: level mode keeps request while low
        phase = "R4";
        mode = 1; steps(2);
        check("R4", lat, 1'b1, "low level sets latch");
        ack = 1; step(); ack = 0;
        check("R4", lat, 1'b1, "ack hidden by low level");
        irq_n = 1; steps(4);
        ack = 1; step(); ack = 0;
        check("R4", lat, 1'b0, "clear after pin high");
        mode = 0; steps(2);

        // R8: mask gates the CPU request, latch still captures
        phase = "R8";
        mask = 1; irq_n = 0; steps(4);
        check("R8", lat, 1'b1, "latched while masked");
        check("R8", cpu, 1'b0, "to_cpu masked");
        mask = 0; step();
        check("R8", cpu, 1'b1, "to_cpu after unmask");
        irq_n = 1; ack = 1; step(); ack = 0; steps(3);

        // R5: unqualified pins ignored
        phase = "R5";
        pu = 8'h00; pin[3] = 0; steps(5);
        check("R5", lat, 1'b0, "pullup off ignored");
        pin[3] = 1; steps(3);
        pu = 8'h08; dout = 8'h08; steps(2);
        pin[3] = 0; steps(5);
        check("R5", lat, 1'b0, "output pin ignored");
        pin[3] = 1; steps(3);
        dout = 8'h00; steps(2);

        // R6: qualified port pin ORed into request
        phase = "R6";
        pin[3] = 0; steps(3);
        check("R6", lat, 1'b1, "port pin fall sets");
        pin[3] = 1; ack = 1; step(); ack = 0; steps(3);
        mode = 1; pu = 8'hFF; pin[6] = 0; steps(3);
        check("R6", lat, 1'b1, "port pin level sets");
        pin[6] = 1; steps(3); ack = 1; step(); ack = 0;
        mode = 0; pu = 8'h00; steps(2);

        // R10: pin enabled while low gives no edge
        phase = "R10";
        dout[5] = 1; pu[5] = 1; pin[5] = 0; steps(4);
        dout[5] = 0; steps(5);
        check("R10", lat, 1'b0, "no spurious edge");
        pin[5] = 1; steps(3); pin[5] = 0; steps(3);
        check("R10", lat, 1'b1, "real edge after enable");
        pin[5] = 1; ack = 1; step(); ack = 0; steps(3);
        pu = 8'h00;

        // R7: edge and ack in same cycle, set wins
        phase = "R7";
        irq_n = 0; steps(2);
        ack = 1; step(); ack = 0;
        check("R7", lat, 1'b1, "set beats clear");
        irq_n = 1; steps(3);

        // R9: watchdog and external reset clear, beat level set
        phase = "R9";
        wd = 1; step(); wd = 0;
        check("R9", lat, 1'b0, "watchdog clears");
        mode = 1; irq_n = 0; steps(3);
        check("R9", lat, 1'b1, "level set before ext reset");
        er = 1; step();
        check("R9", lat, 1'b0, "ext reset beats level");
        er = 0; step();
        check("R9", lat, 1'b1, "level resets after release");
        irq_n = 1; mode = 0; steps(3); ack = 1; step(); ack = 0; steps(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule